// File: doc/BRIEF.md
# Extended 64-bit Integer ALU

This block evaluates one integer operation per cycle on two 64-bit operands and a 7-bit operation code. The top three bits of the code select an operation group: shifts and single-bit operations, 32-bit word operations, add variants, subtract and compare, logic, byte rearrangement, fused logic with a truncated result, and branch compares. Inside the add group there are fused forms that pre-shift or zero-extend the first operand, or take its high part, before the addition. The branch group decodes its compare type and its inversion from fixed bit fields of the code.

When `in_valid` is high at a rising clock edge, the operands are captured and the result is computed from them. The result, the branch `taken` flag and `out_valid` then appear after that same edge. When `in_valid` is low, the result and the flag keep their values and `out_valid` goes low. An operation code that no requirement lists gives a zero result and a clear flag.

Top module: `ext_int_alu`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `result` and `taken` are all 0, whatever the inputs are.
- R2: An operation presented with `in_valid` high at a rising edge shows its `result` and `taken`, with `out_valid` high, after that edge. A cycle with `in_valid` low drives `out_valid` low after the edge and leaves `result` and `taken` unchanged.
- R3: The shift amount and bit index is `src_b[5:0]`. The shift and single-bit codes are:
  - 0x00: zero-extended low word of `src_a`, shifted left.
  - 0x01: shift left.
  - 0x05: logical shift right.
  - 0x07: arithmetic shift right.
  - 0x02, 0x03 and 0x04: clear, set or invert the indexed bit of `src_a`.
  - 0x06: the indexed bit of `src_a`, returned in bit 0 with all other bits 0.
- R4: Code 0x09 rotates `src_a` left and code 0x0B rotates it right, by `src_b[5:0]`. An amount of 0 returns `src_a` unchanged.
- R5: The 32-bit word codes are:
  - 0x10: add.
  - 0x11: bit 0 of `src_a` plus `src_b`.
  - 0x12: subtract.
  - 0x18: shift left.
  - 0x19: logical shift right of the low word of `src_a`.
  - 0x1A: arithmetic shift right of the low word of `src_a`.
  - 0x1C and 0x1D: rotate the low word left or right.
  
  Word shifts take their amount from `src_b[4:0]`. Each of these codes sign-extends bit 31 of its 32-bit result into bits 63..32.
- R6: From the full 64-bit sum `src_a+src_b`, code 0x14 returns bit 0, code 0x15 returns the zero-extended low byte, code 0x16 returns the zero-extended low halfword, and code 0x17 returns the sign-extended low halfword.
- R7: Codes 0x29, 0x2B, 0x2D and 0x2F return `(src_a<<k)+src_b` with k equal to 1, 2, 3 and 4 respectively. Codes 0x28, 0x2A and 0x2C do the same with k equal to 1, 2 and 3, but first zero-extend `src_a[31:0]`.
- R8: Code 0x20 returns the zero-extended low word of `src_a` plus `src_b`. Code 0x21 returns `src_a+src_b`. Code 0x22 returns `src_a[0]+src_b`. Codes 0x24, 0x25, 0x26 and 0x27 add `src_b` to `src_a` logically shifted right by 29, 30, 31 and 32.
- R9: The subtract and compare codes are:
  - 0x30: `src_a-src_b`.
  - 0x31: unsigned less-than, returned as 0 or 1.
  - 0x32: signed less-than, returned as 0 or 1.
  - 0x34 and 0x35: unsigned maximum and minimum.
  - 0x36 and 0x37: signed maximum and minimum.
- R10: The logic codes are:
  - 0x40 and, 0x41 and-not, 0x42 or, 0x43 or-not, 0x44 xor, 0x45 xnor. The "not" forms invert `src_b`.
  - 0x46: each byte of `src_a` becomes 0xFF if it is nonzero and 0x00 otherwise.
  
  The byte codes are:
  - 0x48 and 0x4A: sign-extend the low byte or the low halfword of `src_a`.
  - 0x49: the zero-extended pair {`src_b[7:0]`,`src_a[7:0]`}.
  - 0x4B: the sign-extended pair {`src_b[15:0]`,`src_a[15:0]`}.
  - 0x51: reverse the byte order of `src_a`.
  - 0x52: {`src_b[31:0]`,`src_a[31:0]`}.
- R11: In codes 0x60 to 0x67, bits 2..1 pick a base operation: 0 is and, 1 is or, 2 is xor, 3 is the byte-nonzero mask of `src_a`. Bit 0 then picks the part of the result returned: 0 returns only bit 0 of the base result, and 1 returns its zero-extended low 16 bits.
- R12: In the branch codes, bits 6..4 are 111. Bits 3..2 select the compare: 00 is equal, 10 is signed less-than, 11 is unsigned less-than. Bit 1 inverts the outcome. The valid codes are 0x70, 0x72, 0x78, 0x7A, 0x7C and 0x7E. For these codes `taken` is the outcome and `result` is 0.
- R13: Every code not listed in R3 to R12 returns `result` 0 and `taken` 0. For all non-branch codes `taken` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and code are captured on this edge |
| op | input | 7 | Operation code, group in bits 6..4 |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand, shift amount or bit index |
| out_valid | output | 1 | Result registered from a valid input |
| result | output | 64 | Registered operation result |
| taken | output | 1 | Registered branch outcome |

## Verification
Every result and branch flag is due exactly one rising edge after the cycle in which `in_valid` carried its inputs. Each input pattern is driven on a falling edge. The bench then compares `result`, `taken` and `out_valid` at the next falling edge, after one register stage has updated. In the hold test `in_valid` is held low, new operands are applied, and the outputs are compared one falling edge later against the last valid result. The sweep covers all 128 codes with random operands, equal and sign-boundary pairs, and shift amounts 0, 31, 32 and 63.

// File: rtl/ext_alu_pkg.sv
package ext_alu_pkg;

  typedef enum logic [2:0] {
    GRP_SHIFT  = 3'd0,
    GRP_WORD   = 3'd1,
    GRP_ADD    = 3'd2,
    GRP_SUB    = 3'd3,
    GRP_LOGIC  = 3'd4,
    GRP_BYTE   = 3'd5,
    GRP_FUSED  = 3'd6,
    GRP_BRANCH = 3'd7
  } grp_e;

  localparam int OPW = 7;

  localparam logic [OPW-1:0] OP_SLLIUW   = 7'h00;
  localparam logic [OPW-1:0] OP_SLL      = 7'h01;
  localparam logic [OPW-1:0] OP_BCLR     = 7'h02;
  localparam logic [OPW-1:0] OP_BSET     = 7'h03;
  localparam logic [OPW-1:0] OP_BINV     = 7'h04;
  localparam logic [OPW-1:0] OP_SRL      = 7'h05;
  localparam logic [OPW-1:0] OP_BEXT     = 7'h06;
  localparam logic [OPW-1:0] OP_SRA      = 7'h07;
  localparam logic [OPW-1:0] OP_ROL      = 7'h09;
  localparam logic [OPW-1:0] OP_ROR      = 7'h0B;

  localparam logic [OPW-1:0] OP_ADDW     = 7'h10;
  localparam logic [OPW-1:0] OP_ODDADDW  = 7'h11;
  localparam logic [OPW-1:0] OP_SUBW     = 7'h12;
  localparam logic [OPW-1:0] OP_SUMBIT   = 7'h14;
  localparam logic [OPW-1:0] OP_SUMBYTE  = 7'h15;
  localparam logic [OPW-1:0] OP_SUMZH    = 7'h16;
  localparam logic [OPW-1:0] OP_SUMSH    = 7'h17;
  localparam logic [OPW-1:0] OP_SLLW     = 7'h18;
  localparam logic [OPW-1:0] OP_SRLW     = 7'h19;
  localparam logic [OPW-1:0] OP_SRAW     = 7'h1A;
  localparam logic [OPW-1:0] OP_ROLW     = 7'h1C;
  localparam logic [OPW-1:0] OP_RORW     = 7'h1D;

  localparam logic [OPW-1:0] OP_ADDUW    = 7'h20;
  localparam logic [OPW-1:0] OP_ADD      = 7'h21;
  localparam logic [OPW-1:0] OP_ODDADD   = 7'h22;
  localparam logic [OPW-1:0] OP_HI29ADD  = 7'h24;
  localparam logic [OPW-1:0] OP_HI30ADD  = 7'h25;
  localparam logic [OPW-1:0] OP_HI31ADD  = 7'h26;
  localparam logic [OPW-1:0] OP_HI32ADD  = 7'h27;
  localparam logic [OPW-1:0] OP_SH1ADDUW = 7'h28;
  localparam logic [OPW-1:0] OP_SH1ADD   = 7'h29;
  localparam logic [OPW-1:0] OP_SH2ADDUW = 7'h2A;
  localparam logic [OPW-1:0] OP_SH2ADD   = 7'h2B;
  localparam logic [OPW-1:0] OP_SH3ADDUW = 7'h2C;
  localparam logic [OPW-1:0] OP_SH3ADD   = 7'h2D;
  localparam logic [OPW-1:0] OP_SH4ADD   = 7'h2F;

  localparam logic [OPW-1:0] OP_SUB      = 7'h30;
  localparam logic [OPW-1:0] OP_SLTU     = 7'h31;
  localparam logic [OPW-1:0] OP_SLT      = 7'h32;
  localparam logic [OPW-1:0] OP_MAXU     = 7'h34;
  localparam logic [OPW-1:0] OP_MINU     = 7'h35;
  localparam logic [OPW-1:0] OP_MAX      = 7'h36;
  localparam logic [OPW-1:0] OP_MIN      = 7'h37;

  localparam logic [OPW-1:0] OP_AND      = 7'h40;
  localparam logic [OPW-1:0] OP_ANDN     = 7'h41;
  localparam logic [OPW-1:0] OP_OR       = 7'h42;
  localparam logic [OPW-1:0] OP_ORN      = 7'h43;
  localparam logic [OPW-1:0] OP_XOR      = 7'h44;
  localparam logic [OPW-1:0] OP_XNOR     = 7'h45;
  localparam logic [OPW-1:0] OP_BYTEMASK = 7'h46;
  localparam logic [OPW-1:0] OP_SEXTB    = 7'h48;
  localparam logic [OPW-1:0] OP_PACKB    = 7'h49;
  localparam logic [OPW-1:0] OP_SEXTH    = 7'h4A;
  localparam logic [OPW-1:0] OP_PACKHW   = 7'h4B;
  localparam logic [OPW-1:0] OP_BSWAP    = 7'h51;
  localparam logic [OPW-1:0] OP_PACKW    = 7'h52;

endpackage

// File: rtl/ext_alu_shift.sv
module ext_alu_shift
  import ext_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OPW-1:0]          op,
  input  logic [XLEN-1:0]         a,
  input  logic [$clog2(XLEN)-1:0] shamt,
  output logic [XLEN-1:0]         res
);
  localparam int SHW  = $clog2(XLEN);
  localparam int WORD = XLEN / 2;
  localparam int WSW  = $clog2(WORD);
  localparam logic [SHW:0] FULL_SH  = (SHW+1)'(XLEN);
  localparam logic [WSW:0] FULL_WSH = (WSW+1)'(WORD);

  logic [WSW-1:0]  wsh;
  logic [SHW:0]    inv_sh;
  logic [WSW:0]    inv_wsh;
  logic [XLEN-1:0] bit_mask;
  logic [WORD-1:0] aw;
  logic [WORD-1:0] w_res;
  logic            is_word;

  assign wsh      = shamt[WSW-1:0];
  assign inv_sh   = FULL_SH - {1'b0, shamt};
  assign inv_wsh  = FULL_WSH - {1'b0, wsh};
  assign bit_mask = {{(XLEN-1){1'b0}}, 1'b1} << shamt;
  assign aw       = a[WORD-1:0];

  always_comb begin
    res     = '0;
    w_res   = '0;
    is_word = 1'b0;
    case (op)
      OP_SLLIUW: res = {{WORD{1'b0}}, aw} << shamt;
      OP_SLL:    res = a << shamt;
      OP_BCLR:   res = a & ~bit_mask;
      OP_BSET:   res = a | bit_mask;
      OP_BINV:   res = a ^ bit_mask;
      OP_SRL:    res = a >> shamt;
      OP_BEXT:   res[0] = |(a & bit_mask);
      OP_SRA:    res = $unsigned($signed(a) >>> shamt);
      OP_ROL:    res = (a << shamt) | (a >> inv_sh);
      OP_ROR:    res = (a >> shamt) | (a << inv_sh);
      OP_SLLW: begin is_word = 1'b1; w_res = aw << wsh; end
      OP_SRLW: begin is_word = 1'b1; w_res = aw >> wsh; end
      OP_SRAW: begin is_word = 1'b1; w_res = $unsigned($signed(aw) >>> wsh); end
      OP_ROLW: begin is_word = 1'b1; w_res = (aw << wsh) | (aw >> inv_wsh); end
      OP_RORW: begin is_word = 1'b1; w_res = (aw >> wsh) | (aw << inv_wsh); end
      default: res = '0;
    endcase
    if (is_word) res = {{WORD{w_res[WORD-1]}}, w_res};
  end

endmodule

// File: rtl/ext_alu_arith.sv
module ext_alu_arith
  import ext_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res
);
  localparam int WORD = XLEN / 2;

  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] diff;
  logic [XLEN-1:0] odd_sum;
  logic [XLEN-1:0] a_uw;
  logic            lt_s;
  logic            lt_u;

  assign sum     = a + b;
  assign diff    = a - b;
  assign odd_sum = {{(XLEN-1){1'b0}}, a[0]} + b;
  assign a_uw    = {{WORD{1'b0}}, a[WORD-1:0]};
  assign lt_s    = $signed(a) < $signed(b);
  assign lt_u    = a < b;

  always_comb begin
    res = '0;
    case (op)
      OP_ADDW:     res = {{WORD{sum[WORD-1]}}, sum[WORD-1:0]};
      OP_ODDADDW:  res = {{WORD{odd_sum[WORD-1]}}, odd_sum[WORD-1:0]};
      OP_SUBW:     res = {{WORD{diff[WORD-1]}}, diff[WORD-1:0]};
      OP_SUMBIT:   res[0] = sum[0];
      OP_SUMBYTE:  res = {{(XLEN-8){1'b0}}, sum[7:0]};
      OP_SUMZH:    res = {{(XLEN-16){1'b0}}, sum[15:0]};
      OP_SUMSH:    res = {{(XLEN-16){sum[15]}}, sum[15:0]};
      OP_ADDUW:    res = a_uw + b;
      OP_ADD:      res = sum;
      OP_ODDADD:   res = odd_sum;
      OP_HI29ADD:  res = (a >> 29) + b;
      OP_HI30ADD:  res = (a >> 30) + b;
      OP_HI31ADD:  res = (a >> 31) + b;
      OP_HI32ADD:  res = (a >> 32) + b;
      OP_SH1ADDUW: res = (a_uw << 1) + b;
      OP_SH1ADD:   res = (a << 1) + b;
      OP_SH2ADDUW: res = (a_uw << 2) + b;
      OP_SH2ADD:   res = (a << 2) + b;
      OP_SH3ADDUW: res = (a_uw << 3) + b;
      OP_SH3ADD:   res = (a << 3) + b;
      OP_SH4ADD:   res = (a << 4) + b;
      OP_SUB:      res = diff;
      OP_SLTU:     res[0] = lt_u;
      OP_SLT:      res[0] = lt_s;
      OP_MAXU:     res = lt_u ? b : a;
      OP_MINU:     res = lt_u ? a : b;
      OP_MAX:      res = lt_s ? b : a;
      OP_MIN:      res = lt_s ? a : b;
      default:     res = '0;
    endcase
  end

endmodule

// File: rtl/ext_alu_logic.sv
module ext_alu_logic
  import ext_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res
);
  localparam int WORD  = XLEN / 2;
  localparam int NBYTE = XLEN / 8;

  logic [XLEN-1:0] byte_mask;
  logic [XLEN-1:0] swapped;
  logic [XLEN-1:0] fused_base;
  logic            is_fused;

  for (genvar i = 0; i < NBYTE; i++) begin : g_lane
    assign byte_mask[8*i +: 8] = {8{|a[8*i +: 8]}};
    assign swapped[8*i +: 8]   = a[XLEN-8-8*i +: 8];
  end

  assign is_fused = (grp_e'(op[6:4]) == GRP_FUSED) && !op[3];

  always_comb begin
    case (op[2:1])
      2'd0:    fused_base = a & b;
      2'd1:    fused_base = a | b;
      2'd2:    fused_base = a ^ b;
      default: fused_base = byte_mask;
    endcase
  end

  always_comb begin
    res = '0;
    case (op)
      OP_AND:      res = a & b;
      OP_ANDN:     res = a & ~b;
      OP_OR:       res = a | b;
      OP_ORN:      res = a | ~b;
      OP_XOR:      res = a ^ b;
      OP_XNOR:     res = ~(a ^ b);
      OP_BYTEMASK: res = byte_mask;
      OP_SEXTB:    res = {{(XLEN-8){a[7]}}, a[7:0]};
      OP_PACKB:    res = {{(XLEN-16){1'b0}}, b[7:0], a[7:0]};
      OP_SEXTH:    res = {{(XLEN-16){a[15]}}, a[15:0]};
      OP_PACKHW:   res = {{WORD{b[15]}}, b[15:0], a[15:0]};
      OP_BSWAP:    res = swapped;
      OP_PACKW:    res = {b[WORD-1:0], a[WORD-1:0]};
      default: begin
        if (is_fused) begin
          if (op[0]) res = {{(XLEN-16){1'b0}}, fused_base[15:0]};
          else       res[0] = fused_base[0];
        end
      end
    endcase
  end

endmodule

// File: rtl/ext_alu_branch.sv
module ext_alu_branch
  import ext_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            taken
);
  logic code_ok;
  logic cond;

  assign code_ok = (grp_e'(op[6:4]) == GRP_BRANCH) && !op[0] && (op[3:2] != 2'b01);

  always_comb begin
    case (op[3:2])
      2'b10:   cond = $signed(a) < $signed(b);
      2'b11:   cond = a < b;
      default: cond = (a == b);
    endcase
  end

  assign taken = code_ok & (cond ^ op[1]);

endmodule

// File: rtl/ext_int_alu.sv
module ext_int_alu
  import ext_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic            taken
);
  localparam int SHW = $clog2(XLEN);

  logic [XLEN-1:0] shift_res;
  logic [XLEN-1:0] arith_res;
  logic [XLEN-1:0] logic_res;
  logic            br_taken;
  logic [XLEN-1:0] result_nxt;
  logic            taken_nxt;

  ext_alu_shift #(.XLEN(XLEN)) u_shift (
    .op(op), .a(src_a), .shamt(src_b[SHW-1:0]), .res(shift_res)
  );

  ext_alu_arith #(.XLEN(XLEN)) u_arith (
    .op(op), .a(src_a), .b(src_b), .res(arith_res)
  );

  ext_alu_logic #(.XLEN(XLEN)) u_logic (
    .op(op), .a(src_a), .b(src_b), .res(logic_res)
  );

  ext_alu_branch #(.XLEN(XLEN)) u_branch (
    .op(op), .a(src_a), .b(src_b), .taken(br_taken)
  );

  // each unit drives zero for codes it does not own
  always_comb begin
    result_nxt = shift_res | arith_res | logic_res;
    taken_nxt  = br_taken;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      taken  <= 1'b0;
    end else if (in_valid) begin
      result <= result_nxt;
      taken  <= taken_nxt;
    end
  end

endmodule

// File: rtl/ext_int_alu_checker.sv
module ext_int_alu_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [6:0]      op,
  input logic [XLEN-1:0] src_a,
  input logic [XLEN-1:0] src_b,
  input logic            out_valid,
  input logic [XLEN-1:0] result,
  input logic            taken
);
  localparam int WORD = XLEN / 2;

  logic word_code;
  logic lsb_code;
  assign word_code = op inside {7'h10, 7'h11, 7'h12, 7'h18, 7'h19, 7'h1A, 7'h1C, 7'h1D};
  assign lsb_code  = op inside {7'h06, 7'h14, 7'h31, 7'h32, 7'h60, 7'h62, 7'h64, 7'h66};

  always_comb begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (!out_valid && result == '0 && !taken); // R1
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(taken))); // R2

  AST_LSB_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lsb_code) |=> (result[XLEN-1:1] == '0)); // R11

  AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && word_code) |=> (result[XLEN-1:WORD] == {WORD{result[WORD-1]}})); // R5

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 7'h21) |=> (result == $past(src_a + src_b))); // R8

  AST_BRANCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[6:4] == 3'b111) |=> (result == '0)); // R12

  AST_EQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 7'h70) |=> (taken == $past(src_a == src_b))); // R12

  AST_NO_TAKEN_ELSEWHERE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[6:4] != 3'b111) |=> !taken); // R13

endmodule

bind ext_int_alu ext_int_alu_checker #(.XLEN(XLEN)) u_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
  .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
  .result(result), .taken(taken)
);

// File: tb/ext_int_alu_test.sv
module ext_int_alu_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [6:0]  op;
  logic [63:0] src_a;
  logic [63:0] src_b;
  logic        out_valid;
  logic [63:0] result;
  logic        taken;

  int total;
  int bad;
  int cycles;
  bit finished;

  ext_int_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
    .result(result), .taken(taken)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] sx32(logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] rot_l(logic [63:0] v, int s);
    logic [127:0] t;
    t = {v, v} << s;
    return t[127:64];
  endfunction

  function automatic logic [31:0] rot_l32(logic [31:0] v, int s);
    logic [63:0] t;
    t = {v, v} << s;
    return t[63:32];
  endfunction

  function automatic logic [63:0] nz_bytes(logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = (v[8*i +: 8] != 0) ? 8'hFF : 8'h00;
    return r;
  endfunction

  function automatic logic [63:0] ref_res(input logic [6:0] o, input logic [63:0] a,
                                          input logic [63:0] b, output bit known);
    int s;
    int ws;
    logic [63:0] sm;
    logic [63:0] uw;
    s  = int'(b[5:0]);
    ws = int'(b[4:0]);
    sm = a + b;
    uw = {32'd0, a[31:0]};
    known = 1'b1;
    case (o)
      7'h00: return uw << s;
      7'h01: return a << s;
      7'h02: return a & ~(64'd1 << s);
      7'h03: return a | (64'd1 << s);
      7'h04: return a ^ (64'd1 << s);
      7'h05: return a >> s;
      7'h06: return {63'd0, a[s]};
      7'h07: return $unsigned($signed(a) >>> s);
      7'h09: return rot_l(a, s);
      7'h0B: return rot_l(a, (64 - s) % 64);
      7'h10: return sx32(sm[31:0]);
      7'h11: return sx32(a[0] + b[31:0]);
      7'h12: return sx32(a[31:0] - b[31:0]);
      7'h14: return {63'd0, sm[0]};
      7'h15: return {56'd0, sm[7:0]};
      7'h16: return {48'd0, sm[15:0]};
      7'h17: return {{48{sm[15]}}, sm[15:0]};
      7'h18: return sx32(a[31:0] << ws);
      7'h19: return sx32(a[31:0] >> ws);
      7'h1A: return sx32($unsigned($signed(a[31:0]) >>> ws));
      7'h1C: return sx32(rot_l32(a[31:0], ws));
      7'h1D: return sx32(rot_l32(a[31:0], (32 - ws) % 32));
      7'h20: return uw + b;
      7'h21: return sm;
      7'h22: return b + a[0];
      7'h24: return b + (a >> 29);
      7'h25: return b + (a >> 30);
      7'h26: return b + (a >> 31);
      7'h27: return b + (a >> 32);
      7'h28: return b + uw * 2;
      7'h29: return b + a * 2;
      7'h2A: return b + uw * 4;
      7'h2B: return b + a * 4;
      7'h2C: return b + uw * 8;
      7'h2D: return b + a * 8;
      7'h2F: return b + a * 16;
      7'h30: return a - b;
      7'h31: return (a < b) ? 64'd1 : 64'd0;
      7'h32: return ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
      7'h34: return (a > b) ? a : b;
      7'h35: return (a < b) ? a : b;
      7'h36: return ($signed(a) > $signed(b)) ? a : b;
      7'h37: return ($signed(a) < $signed(b)) ? a : b;
      7'h40: return a & b;
      7'h41: return a & ~b;
      7'h42: return a | b;
      7'h43: return a | ~b;
      7'h44: return a ^ b;
      7'h45: return a ^ ~b;
      7'h46: return nz_bytes(a);
      7'h48: return {{56{a[7]}}, a[7:0]};
      7'h49: return {48'd0, b[7:0], a[7:0]};
      7'h4A: return {{48{a[15]}}, a[15:0]};
      7'h4B: return {{32{b[15]}}, b[15:0], a[15:0]};
      7'h51: for (int i = 0; i < 8; i++) sm[8*i +: 8] = a[8*(7-i) +: 8];
      7'h52: return {b[31:0], a[31:0]};
      7'h60: return (a & b) & 64'h1;
      7'h61: return (a & b) & 64'hFFFF;
      7'h62: return (a | b) & 64'h1;
      7'h63: return (a | b) & 64'hFFFF;
      7'h64: return (a ^ b) & 64'h1;
      7'h65: return (a ^ b) & 64'hFFFF;
      7'h66: return nz_bytes(a) & 64'h1;
      7'h67: return nz_bytes(a) & 64'hFFFF;
      7'h70, 7'h72, 7'h78, 7'h7A, 7'h7C, 7'h7E: return 64'd0;
      default: begin known = 1'b0; return 64'd0; end
    endcase
    return sm;
  endfunction

  function automatic logic ref_tk(logic [6:0] o, logic [63:0] a, logic [63:0] b);
    case (o)
      7'h70: return a == b;
      7'h72: return a != b;
      7'h78: return $signed(a) < $signed(b);
      7'h7A: return $signed(a) >= $signed(b);
      7'h7C: return a < b;
      7'h7E: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_tag(logic [6:0] o, bit known);
    if (!known) return "R13";
    case (o[6:4])
      3'd0: return (o == 7'h09 || o == 7'h0B) ? "R4" : "R3";
      3'd1: return (o >= 7'h14 && o <= 7'h17) ? "R6" : "R5";
      3'd2: return (o == 7'h28 || o == 7'h2A || o == 7'h2C || o[0]) && o >= 7'h28 ? "R7" : "R8";
      3'd3: return "R9";
      3'd6: return "R11";
      3'd7: return "R12";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act_r, logic [63:0] exp_r,
                       logic act_t, logic exp_t);
    total++;
    if (act_r !== exp_r || act_t !== exp_t) begin
      bad++;
      $display("FAIL %s op=%02h result=%016h expected=%016h taken=%0b expected=%0b",
               tag, op, act_r, exp_r, act_t, exp_t);
    end
  endtask

  task automatic apply(logic [6:0] o, logic [63:0] a, logic [63:0] b);
    logic [63:0] er;
    logic et;
    bit kn;
    er = ref_res(o, a, b, kn);
    et = ref_tk(o, a, b);
    @(negedge clk);
    in_valid = 1'b1; op = o; src_a = a; src_b = b;
    @(negedge clk);
    check(req_tag(o, kn), result, er, taken, et);
    total++;
    if (out_valid !== 1'b1) begin
      bad++;
      $display("FAIL R2 out_valid=%0b expected=1", out_valid);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > MAX_CYCLES && !finished) begin
        finished = 1'b1;
        total++; bad++;
        $display("FAIL watchdog cycles=%0d expected<=%0d", cycles, MAX_CYCLES);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] ra;
    logic [63:0] keep_r;
    logic        keep_t;
    int amts[4];
    total = 0; bad = 0; finished = 1'b0;
    amts[0] = 0; amts[1] = 31; amts[2] = 32; amts[3] = 63;
    rst_n = 1'b0; in_valid = 1'b0; op = 7'h21;
    src_a = 64'h1234; src_b = 64'h5678;
    repeat (2) @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    // R1: outputs stay clear in reset even with a valid input
    check("R1", result, 64'd0, taken, 1'b0);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1 out_valid=%0b expected=0", out_valid);
    end
    in_valid = 1'b0;
    rst_n = 1'b1;

    for (int o = 0; o < 128; o++) begin
      for (int k = 0; k < 6; k++) apply(7'(o), rnd64(), rnd64());
      for (int k = 0; k < 4; k++) begin
        ra = rnd64();
        apply(7'(o), ra, {rnd64() & ~64'h3F} | 64'(amts[k]));
        apply(7'(o), {1'b1, ra[62:0]}, 64'(amts[k]));
      end
      ra = rnd64();
      apply(7'(o), ra, ra);
      apply(7'(o), 64'd0, 64'd0);
      apply(7'(o), 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000);
      apply(7'(o), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
      apply(7'(o), 64'h0000_0000_8000_8080, 64'h0000_0000_7FFF_FFFF);
    end

    // R2: idle cycles hold the outputs
    apply(7'h78, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    keep_r = result;
    keep_t = taken;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b0; op = 7'h21; src_a = rnd64(); src_b = rnd64();
      @(negedge clk);
      check("R2", result, keep_r, taken, keep_t);
      total++;
      if (out_valid !== 1'b0) begin
        bad++;
        $display("FAIL R2 out_valid=%0b expected=0", out_valid);
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule